// File: doc/BRIEF.md
# Local Access Window Decoder

This block decides which target interface of a chip must serve a real address. It holds a bank of programmable windows. Each window is a naturally aligned, power-of-two sized region with an enable, a base and a target-interface ID. A request presents one 32-bit address. One cycle later the block reports one of three outcomes: the target ID and index of the window that claimed the address, a claim by the internal configuration register block, or a no-target error.

Boot software programs the windows through a small 32-bit register port. The port has a write strobe and a read strobe and uses byte offsets inside the configuration space. The windows sit at a fixed stride, so the setup code can loop over a table of base and attribute pairs. The address region of the internal configuration block is fixed by parameters. It never needs a window and takes precedence over every window.

Top module: `law_decoder`

## Requirements
- R1: After reset every window is disabled with all fields zero, all response outputs and `reg_rdata` are zero, and a request that misses the configuration region returns the no-target error.
- R2: Window i (0 to 9) has its base register at byte offset 0xC28 + 0x20*i and its attribute register at offset 0xC30 + 0x20*i. A write to any other offset changes nothing, and a read of any other offset returns zero.
- R3: The base register keeps bits [19:0], which are address bits 31:12, and reads bits [31:20] as zero. The attribute register keeps enable in bit 31, the target ID in bits [23:20] and the size code in bits [5:0], and reads every other bit as zero.
- R4: `reg_rdata` shows the addressed register in the cycle after `reg_rd` is high and holds its value while `reg_rd` is low.
- R5: An enabled window with size code k claims an address when address bits [31:k+1] equal the same bits of the base register shifted left by 12. A disabled window claims nothing.
- R6: Size code k gives a window of 2^(k+1) bytes. Codes below 11 act as 4 KB, and codes above 31 act as the full 4 GB space.
- R7: When several windows claim an address, the lowest-numbered window supplies `rsp_tgt` and `rsp_win`.
- R8: When no window claims a request, `rsp_err` is 1 and `rsp_hit`, `rsp_tgt` and `rsp_win` are 0.
- R9: An address whose bits [31:20] equal 0xFF7 raises `rsp_cfg` with `rsp_hit` and `rsp_err` low, whatever the windows hold.
- R10: The response outputs are registered and valid in the cycle after `req_valid`. In a cycle that follows no request, all of them are zero.
- R11: A register write takes effect for requests presented in the next cycle or later. A request presented in the same cycle as the write is decoded with the settings held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |
| req_valid | input | 1 | Address request valid |
| req_addr | input | 32 | Real address to decode |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | A window claimed the address |
| rsp_tgt | output | 4 | Target ID of the claiming window |
| rsp_win | output | 4 | Index of the claiming window |
| rsp_err | output | 1 | No window claimed the address |
| rsp_cfg | output | 1 | Address lies in the configuration register block |

## Verification
Directed requests probe each window just inside and just outside its upper and lower edges. These show whether the size code is turned into the correct mask, including the clamped codes at 4 KB and at 4 GB. Overlapping windows with different indices separate a lowest-index priority from a highest-index one. A write and a request in the same cycle show whether a setting takes effect a cycle too early. Writes of all ones and reads of offsets between, beside and beyond the register slots test the field masks and the decoding of the slots. A long run of mixed random requests, writes and reads near window boundaries and inside the configuration region is then compared with the behavioural model on every cycle.

// File: rtl/lawd_pkg.sv
package lawd_pkg;
  localparam int ADDR_W     = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int BASE_W     = ADDR_W - PAGE_SHIFT;
  localparam int TGT_W      = 4;
  localparam int SIZE_W     = 6;
  localparam int EN_BIT     = 31;
  localparam int TGT_LSB    = 20;
  localparam int MIN_CODE   = PAGE_SHIFT - 1;
  localparam int MAX_CODE   = ADDR_W - 1;

  typedef struct packed {
    logic             en;
    logic [TGT_W-1:0] tgt;
    logic [SIZE_W-1:0] size;
  } win_attr_t;
endpackage

// File: rtl/lawd_regfile.sv
module lawd_regfile
  import lawd_pkg::*;
#(
  parameter int NUM_WIN     = 10,
  parameter int REG_AW      = 12,
  parameter int BASE_OFF    = 'hC28,
  parameter int ATTR_OFF    = 'hC30,
  parameter int STRIDE_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [BASE_W-1:0] base_q [NUM_WIN],
  output win_attr_t         attr_q [NUM_WIN]
);
  localparam int SLOT_W     = REG_AW - STRIDE_LOG2;
  localparam int ATTR_DELTA = ATTR_OFF - BASE_OFF;

  logic [REG_AW-1:0]      rel;
  logic [SLOT_W-1:0]      slot;
  logic [STRIDE_LOG2-1:0] sub;
  logic                   in_range, sel_base, sel_attr;
  logic [31:0]            rd_word;
  logic                   unused_wdata;

  assign rel      = reg_addr - REG_AW'(BASE_OFF);
  assign slot     = rel[REG_AW-1:STRIDE_LOG2];
  assign sub      = rel[STRIDE_LOG2-1:0];
  assign in_range = (reg_addr >= REG_AW'(BASE_OFF)) && (slot < SLOT_W'(NUM_WIN));
  assign sel_base = in_range && (sub == '0);
  assign sel_attr = in_range && (sub == STRIDE_LOG2'(ATTR_DELTA));
  assign unused_wdata = ^{reg_wdata[30:24], reg_wdata[19:6]};

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[i] <= '0;
        attr_q[i] <= '0;
      end else if (reg_wr && slot == SLOT_W'(i)) begin
        if (sel_base) base_q[i] <= reg_wdata[BASE_W-1:0];
        if (sel_attr) attr_q[i] <= '{en:   reg_wdata[EN_BIT],
                                     tgt:  reg_wdata[TGT_LSB +: TGT_W],
                                     size: reg_wdata[SIZE_W-1:0]};
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (slot == SLOT_W'(i)) begin
        if (sel_base) rd_word[BASE_W-1:0] = base_q[i];
        if (sel_attr) begin
          rd_word[EN_BIT]             = attr_q[i].en;
          rd_word[TGT_LSB +: TGT_W]   = attr_q[i].tgt;
          rd_word[SIZE_W-1:0]         = attr_q[i].size;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_word;
  end

  // R2
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !sel_base && !sel_attr) |=> (reg_rdata == '0));

  // R4
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: rtl/lawd_match.sv
module lawd_match
  import lawd_pkg::*;
#(
  parameter int NUM_WIN = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BASE_W-1:0] base_q [NUM_WIN],
  input  win_attr_t         attr_q [NUM_WIN],
  output logic [NUM_WIN-1:0] match
);
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
    logic [SIZE_W:0]   nbits;
    logic [ADDR_W-1:0] mask, base_addr;

    always_comb begin
      if (attr_q[i].size < SIZE_W'(MIN_CODE))      nbits = (SIZE_W+1)'(MIN_CODE + 1);
      else if (attr_q[i].size > SIZE_W'(MAX_CODE)) nbits = (SIZE_W+1)'(MAX_CODE + 1);
      else                                         nbits = {1'b0, attr_q[i].size} + 1'b1;
    end

    assign mask      = {ADDR_W{1'b1}} << nbits;
    assign base_addr = {base_q[i], {PAGE_SHIFT{1'b0}}};
    assign match[i]  = attr_q[i].en && (((addr ^ base_addr) & mask) == '0);

    // R5
    disabled_no_match_chk: assert property (@(posedge clk) disable iff (rst)
      !attr_q[i].en |-> !match[i]);

    // R6
    full_space_match_chk: assert property (@(posedge clk) disable iff (rst)
      (attr_q[i].en && attr_q[i].size >= SIZE_W'(MAX_CODE)) |-> match[i]);
  end
endmodule

// File: rtl/lawd_select.sv
module lawd_select
  import lawd_pkg::*;
#(
  parameter int NUM_WIN  = 10,
  parameter int CFG_LOG2 = 20,
  parameter int CFG_BASE = 'hFF70_0000,
  localparam int IDX_W   = $clog2(NUM_WIN),
  localparam int CFG_W   = ADDR_W - CFG_LOG2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [CFG_W-1:0]   addr_hi,
  input  logic [NUM_WIN-1:0] match,
  input  logic [TGT_W-1:0]   tgt_q [NUM_WIN],
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [TGT_W-1:0]   rsp_tgt,
  output logic [IDX_W-1:0]   rsp_win,
  output logic               rsp_err,
  output logic               rsp_cfg
);
  localparam logic [ADDR_W-1:0] CFG_FULL = ADDR_W'(CFG_BASE);

  logic             any, is_cfg, take;
  logic [IDX_W-1:0] win_n;
  logic [TGT_W-1:0] tgt_n;

  assign is_cfg = (addr_hi == CFG_FULL[ADDR_W-1:CFG_LOG2]);

  always_comb begin
    any   = 1'b0;
    win_n = '0;
    tgt_n = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match[i]) begin
        any   = 1'b1;
        win_n = IDX_W'(i);
        tgt_n = tgt_q[i];
      end
    end
  end

  assign take = req_valid && !is_cfg && any;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_cfg   <= 1'b0;
      rsp_tgt   <= '0;
      rsp_win   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_cfg   <= req_valid && is_cfg;
      rsp_hit   <= take;
      rsp_err   <= req_valid && !is_cfg && !any;
      rsp_tgt   <= take ? tgt_n : '0;
      rsp_win   <= take ? win_n : '0;
    end
  end

  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && !rsp_hit && !rsp_err && !rsp_cfg);

  // R9
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_hit, rsp_err, rsp_cfg}) == 1);

  // R8
  err_means_no_match_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && match != '0) |=> !rsp_err);
endmodule

// File: rtl/law_decoder.sv
module law_decoder
  import lawd_pkg::*;
#(
  parameter int NUM_WIN     = 10,
  parameter int REG_AW      = 12,
  parameter int BASE_OFF    = 'hC28,
  parameter int ATTR_OFF    = 'hC30,
  parameter int STRIDE_LOG2 = 5,
  parameter int CFG_LOG2    = 20,
  parameter int CFG_BASE    = 'hFF70_0000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [REG_AW-1:0]          reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  input  logic                       req_valid,
  input  logic [31:0]                req_addr,
  output logic                       rsp_valid,
  output logic                       rsp_hit,
  output logic [3:0]                 rsp_tgt,
  output logic [$clog2(NUM_WIN)-1:0] rsp_win,
  output logic                       rsp_err,
  output logic                       rsp_cfg
);
  logic [BASE_W-1:0]  base_q [NUM_WIN];
  win_attr_t          attr_q [NUM_WIN];
  logic [TGT_W-1:0]   tgt_q  [NUM_WIN];
  logic [NUM_WIN-1:0] match;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_tgt
    assign tgt_q[i] = attr_q[i].tgt;
  end

  lawd_regfile #(
    .NUM_WIN(NUM_WIN), .REG_AW(REG_AW), .BASE_OFF(BASE_OFF),
    .ATTR_OFF(ATTR_OFF), .STRIDE_LOG2(STRIDE_LOG2)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .base_q(base_q), .attr_q(attr_q)
  );

  lawd_match #(.NUM_WIN(NUM_WIN)) u_match (
    .clk(clk), .rst(rst), .addr(req_addr),
    .base_q(base_q), .attr_q(attr_q), .match(match)
  );

  lawd_select #(
    .NUM_WIN(NUM_WIN), .CFG_LOG2(CFG_LOG2), .CFG_BASE(CFG_BASE)
  ) u_sel (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .addr_hi(req_addr[ADDR_W-1:CFG_LOG2]), .match(match), .tgt_q(tgt_q),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_tgt(rsp_tgt),
    .rsp_win(rsp_win), .rsp_err(rsp_err), .rsp_cfg(rsp_cfg)
  );
endmodule

// File: tb/sim_law_decoder.sv
module sim_law_decoder;
  localparam int NW = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr, reg_rd, req_valid;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, req_addr, reg_rdata;
  logic        rsp_valid, rsp_hit, rsp_err, rsp_cfg;
  logic [3:0]  rsp_tgt, rsp_win;

  int checks = 0;
  int failures = 0;

  logic [31:0] m_base [NW];
  logic [31:0] m_attr [NW];
  logic [31:0] exp_rdata;
  logic [43:0] exp_vec;

  always #4 clk = ~clk;

  law_decoder u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_tgt(rsp_tgt), .rsp_win(rsp_win), .rsp_err(rsp_err), .rsp_cfg(rsp_cfg)
  );

  function automatic logic [11:0] boff(int i); return 12'(12'hC28 + i * 32); endfunction
  function automatic logic [11:0] aoff(int i); return 12'(12'hC30 + i * 32); endfunction
  function automatic logic [31:0] attr(bit en, int tgt, int code);
    return {en, 7'b0, 4'(tgt), 14'b0, 6'(code)};
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a);
    int rel, slot, sub;
    if (a < 12'hC28) return 32'h0;
    rel = int'(a) - 'hC28; slot = rel / 32; sub = rel % 32;
    if (slot >= NW) return 32'h0;
    if (sub == 0) return m_base[slot];
    if (sub == 8) return m_attr[slot];
    return 32'h0;
  endfunction

  task automatic m_write(logic [11:0] a, logic [31:0] d);
    int rel, slot, sub;
    if (a < 12'hC28) return;
    rel = int'(a) - 'hC28; slot = rel / 32; sub = rel % 32;
    if (slot >= NW) return;
    if (sub == 0) m_base[slot] = d & 32'h000F_FFFF;
    if (sub == 8) m_attr[slot] = d & 32'h80F0_003F;
  endtask

  // response vector: valid,hit,err,cfg,tgt[3:0],win[3:0],rdata[31:0]
  function automatic logic [43:0] m_decode(bit rv, logic [31:0] ra, logic [31:0] rd);
    logic [63:0] x;
    int k;
    if (!rv) return {12'h0, rd};
    if (ra[31:20] == 12'hFF7) return {4'b1001, 8'h0, rd};
    for (int i = 0; i < NW; i++) begin
      if (m_attr[i][31]) begin
        k = int'(m_attr[i][5:0]);
        if (k < 11) k = 11;
        if (k > 31) k = 31;
        x = {32'h0, ra ^ (m_base[i] << 12)};
        if ((x >> (k + 1)) == 64'h0) return {4'b1100, m_attr[i][23:20], 4'(i), rd};
      end
    end
    return {4'b1010, 8'h0, rd};
  endfunction

  task automatic step(bit wr, bit rd, logic [11:0] a, logic [31:0] d,
                      bit rv, logic [31:0] ra, string tag);
    logic [43:0] act;
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    req_valid = rv; req_addr = ra;
    if (rd) exp_rdata = m_read(a);
    exp_vec = m_decode(rv, ra, exp_rdata);
    if (wr) m_write(a, d);
    @(posedge clk);
    @(negedge clk);
    act = {rsp_valid, rsp_hit, rsp_err, rsp_cfg, rsp_tgt, rsp_win, reg_rdata};
    checks++;
    if (act !== exp_vec) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h (addr=%h)", tag, act, exp_vec, ra);
    end
  endtask

  task automatic req(logic [31:0] ra, string tag);
    step(0, 0, 12'h0, 32'h0, 1, ra, tag);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
    step(1, 0, a, d, 0, 32'h0, tag);
  endtask

  task automatic rd(logic [11:0] a, string tag);
    step(0, 1, a, 32'h0, 0, 32'h0, tag);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) begin m_base[i] = 0; m_attr[i] = 0; end
    exp_rdata = 0;
    rst = 1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    req_valid = 0; req_addr = 0;
    repeat (3) @(negedge clk);
    // R1: outputs zero during reset
    checks++;
    if ({rsp_valid, rsp_hit, rsp_err, rsp_cfg, rsp_tgt, rsp_win, reg_rdata} !== 44'h0) begin
      failures++;
      $display("FAIL R1 reset: actual=%h expected=0",
               {rsp_valid, rsp_hit, rsp_err, rsp_cfg, rsp_tgt, rsp_win, reg_rdata});
    end
    rst = 0;
    step(0, 0, 0, 0, 0, 0, "R10 idle");
    req(32'h1234_5678, "R1 miss after reset");
    rd(aoff(0), "R1 attr zero after reset");

    // 2 GB window 0 at 0, target 3
    wr(boff(0), 32'h0, "R2 base0");
    step(1, 0, aoff(0), attr(1, 3, 30), 1, 32'h1000_0000, "R11 same-cycle write uses old");
    req(32'h1000_0000, "R11 next cycle sees write");
    req(32'h7FFF_FFFF, "R5 top of 2GB");
    req(32'h8000_0000, "R8 just above 2GB");

    // overlapping windows: win3 512MB at C000_0000 tgt 4, win2 256MB tgt 2
    wr(boff(3), 32'h000C_0000, "R2 base3");
    wr(aoff(3), attr(1, 4, 28), "R2 attr3");
    wr(boff(2), 32'h000C_0000, "R2 base2");
    wr(aoff(2), attr(1, 2, 27), "R2 attr2");
    req(32'hC100_0000, "R7 lowest index wins");
    req(32'hD000_0000, "R6 512MB upper half");
    req(32'hE000_0000, "R8 past 512MB");
    req(32'hBFFF_FFFF, "R5 just below base");

    // small code clamps to 4KB
    wr(boff(5), 32'h000F_8000, "R2 base5");
    wr(aoff(5), attr(1, 9, 5), "R2 attr5");
    req(32'hF800_0FFF, "R6 4KB clamp inside");
    req(32'hF800_1000, "R6 4KB clamp outside");

    // window 9 4MB at FFC0_0000
    wr(boff(9), 32'h000F_FC00, "R2 base9");
    wr(aoff(9), attr(1, 6, 21), "R2 attr9");
    req(32'hFFFF_FFFC, "R5 window9 hit");
    req(32'hFFBF_FFFF, "R5 window9 below");
    req(32'hFF70_0010, "R9 cfg region");

    // disable via enable bit
    wr(aoff(5), attr(0, 9, 5), "R5 disable");
    req(32'hF800_0000, "R5 disabled window ignored");

    // register field masks and unmapped offsets
    wr(boff(1), 32'hFFFF_FFFF, "R3 base mask");
    rd(boff(1), "R3 base reads masked");
    wr(aoff(1), 32'h7FFF_FFFF, "R3 attr mask");
    rd(aoff(1), "R3 attr reads masked");
    wr(12'hC2C, 32'hFFFF_FFFF, "R2 gap write");
    rd(12'hC2C, "R2 gap reads zero");
    rd(12'hD68, "R2 beyond last window");
    rd(12'h000, "R2 low offset");
    rd(boff(9), "R2 window9 base offset");
    step(0, 0, 0, 0, 0, 0, "R4 rdata held");
    step(1, 1, boff(9), 32'h1, 0, 0, "R4 read same cycle as write");
    rd(boff(9), "R4 read after write");

    // full-space window: code 63 in window 4, others lower disabled
    for (int i = 0; i < 4; i++) wr(aoff(i), 32'h0, "R5 clear");
    wr(aoff(4), attr(1, 11, 63), "R6 code above 31");
    req(32'h0000_0000, "R6 full space low");
    req(32'hFFFF_0000, "R7 window4 over window9");
    req(32'hFF7F_FFFF, "R9 cfg over full window");

    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      int pick;
      logic [31:0] ra;
      logic [11:0] a;
      pick = $urandom_range(0, NW - 1);
      a = ($urandom_range(0, 1) == 0) ? boff(pick) : aoff(pick);
      if ($urandom_range(0, 7) == 0) a = 12'($urandom_range(12'hC00, 12'hD80));
      ra = $urandom;
      if ($urandom_range(0, 3) == 0) ra = (m_base[pick] << 12) + $urandom_range(0, 32'h0000_3000) - 32'h1000;
      if ($urandom_range(0, 15) == 0) ra = {12'hFF7, 20'($urandom)};
      step($urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0, a,
           ($urandom_range(0, 1) == 0) ? attr($urandom_range(0, 1) == 1, $urandom_range(0, 15), $urandom_range(0, 63))
                                       : 32'($urandom),
           $urandom_range(0, 3) != 0, ra, "R5 R7 R8 R11 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule